// File: doc/BRIEF.md
# UART Interrupt Cause and Status Register

This block gathers the interrupt causes of a serial port and presents them, together with the line status byte, the modem status byte and the receive fill count, in one packed 32-bit status word on a plain register bus. Four causes arrive as single-cycle event strobes: line status, receive data available, character timeout and transmit space available. The fifth cause, modem status change, is raised inside the block whenever one of the four modem input levels changes. Each level change also sets its own delta flag.

Software reads the status word and acknowledges causes by writing their bits back. Several causes can be pending at once. A second word holds the per-cause enables and two 3-bit trigger-level codes. The block decodes these codes into byte thresholds for the transmit and receive FIFOs. One level-sensitive interrupt output is high while any enabled cause is pending.

The register bus has no back-pressure. A write (`bus_wr` high at a rising clock edge) takes effect at that edge, and a read is combinational on `bus_addr`. The FIFOs, the shifters and the modem pins are outside this block and supply the strobes and levels.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, the cause field (status bits 4:0), the modem delta flags (status bits 11:8), the configuration word and `irq` are all zero.
- R2: Each event strobe sets its cause bit at the next clock edge, and the bit then stays set until it is cleared. The bit positions are: 0 line status, 1 receive data available, 2 character timeout, 3 transmit space available. Several bits may be set together.
- R3: A status write with byte lane 0 enabled clears exactly the cause bits set in `bus_wdata[4:0]`. The other cause bits are unchanged.
- R4: If an event sets a cause bit in the same cycle that a write clears it, the bit stays set.
- R5: A cause latches whether or not it is enabled. `irq` is high exactly when some pending cause has its enable set. The enables are configuration bits: 0 receive, 1 transmit space, 2 line status, 3 modem status.
- R6: The receive enable (configuration bit 0) gates both the receive-data-available cause and the character-timeout cause.
- R7: A change of a modem level sets its delta flag (status bits 8..11 for CTS, DSR, RI, DCD) and sets cause bit 4. The current levels are shown in status bits 12..15 in the same order.
- R8: Clearing cause bit 4 also clears all four modem delta flags.
- R9: Status bits 23:16 show the line status byte input unchanged.
- R10: Receive fill count bits 7:0 appear in status bits 31:24 and bits 9:8 in status bits 7:6. Status bit 5 reads zero. Writing to the status address leaves these fields unchanged.
- R11: The configuration word reads back its enables in bits 3:0, the transmit trigger code in bits 19:16 and the receive trigger code in bits 23:20. All other bits read zero. Byte lane 0 writes the enables and byte lane 2 writes the codes.
- R12: Each threshold output equals 2^(code+2) bytes, where code is bits 2:0 of its trigger field. Code 5 gives 128 and code 6 gives 256.
- R13: A status write without byte lane 0 enabled clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address; STAT_IDX selects status, CONF_IDX selects configuration |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (zero for other addresses) |
| ls_evt | input | 1 | Line status event strobe |
| rda_evt | input | 1 | Receive data available strobe |
| cto_evt | input | 1 | Character timeout strobe |
| tsa_evt | input | 1 | Transmit space available strobe |
| modem_lvl | input | 4 | Modem levels: bit 0 CTS, 1 DSR, 2 RI, 3 DCD |
| line_stat | input | 8 | Line status byte |
| rx_fill | input | 10 | Receive FIFO fill count |
| irq | output | 1 | Level interrupt |
| tx_thresh | output | 10 | Decoded transmit trigger threshold in bytes |
| rx_thresh | output | 10 | Decoded receive trigger threshold in bytes |

## Verification
The bench builds the block with its default parameters: a 4-bit word address, the status word at index 0 and the configuration word at index 1. With these defaults, the bench sweeps all eight trigger codes on both threshold outputs. It drives fill counts whose top two bits are non-zero, which exercises the split field. It walks every enable against every cause, so each gating path, including the shared receive enable, is covered.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NCAUSE  = 5;
  localparam int NMODEM  = 4;
  localparam int FILL_W  = 10;
  localparam int CODE_W  = 3;
  localparam int TH_W    = (1 << CODE_W) + 2;

  localparam int C_LS  = 0;
  localparam int C_RDA = 1;
  localparam int C_CTO = 2;
  localparam int C_TSA = 3;
  localparam int C_MS  = 4;

  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;
endpackage

// File: rtl/uirq_cause.sv
module uirq_cause
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [C_MS-1:0]   ev_in,
  input  logic [NMODEM-1:0] modem_lvl,
  input  logic              clr_valid,
  input  logic [NCAUSE-1:0] clr_mask,
  output logic [NCAUSE-1:0] cause,
  output logic [NMODEM-1:0] delta
);
  logic [NMODEM-1:0] lvl_q;
  logic [NMODEM-1:0] chg;
  logic [NCAUSE-1:0] set_v;
  logic [NCAUSE-1:0] clr_v;

  always_comb begin
    chg   = modem_lvl ^ lvl_q;
    set_v = {|chg, ev_in};
    clr_v = clr_valid ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause <= '0;
      delta <= '0;
      lvl_q <= '0;
    end else begin
      lvl_q <= modem_lvl;
      cause <= (cause & ~clr_v) | set_v;
      delta <= (clr_v[C_MS] ? '0 : delta) | chg;
    end
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((cause & $past(set_v)) == $past(set_v)));

  p_clear_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_v & ~set_v) != '0) |=> ((cause & $past(clr_v & ~set_v)) == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v == '0 && clr_v == '0) |=> $stable(cause));

  p_delta_implies_ms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (delta != '0) |-> cause[C_MS]);

  p_delta_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v[C_MS] && chg == '0) |=> (delta == '0));
endmodule

// File: rtl/uirq_cfg.sv
module uirq_cfg
  import uirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [3:0]  en,
  output logic [3:0]  tx_code,
  output logic [3:0]  rx_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= '0;
      tx_code <= '0;
      rx_code <= '0;
    end else if (we) begin
      if (be[0]) en <= wdata[3:0];
      if (be[2]) begin
        tx_code <= wdata[19:16];
        rx_code <= wdata[23:20];
      end
    end
  end

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(en) && $stable(tx_code) && $stable(rx_code)));
endmodule

// File: rtl/uirq_thresh.sv
module uirq_thresh
  import uirq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [TH_W-1:0]   bytes_out
);
  always_comb begin
    bytes_out = '0;
    for (int k = 0; k < (1 << CODE_W); k++)
      if (code == CODE_W'(k)) bytes_out[k + 2] = 1'b1;
  end

  always_comb begin
    a_thresh_onehot_r12: assert ($onehot(bytes_out));
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int STAT_IDX = 0,
  parameter int CONF_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ls_evt,
  input  logic              rda_evt,
  input  logic              cto_evt,
  input  logic              tsa_evt,
  input  logic [3:0]        modem_lvl,
  input  logic [7:0]        line_stat,
  input  logic [9:0]        rx_fill,
  output logic              irq,
  output logic [9:0]        tx_thresh,
  output logic [9:0]        rx_thresh
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_IDX);
  localparam logic [ADDR_W-1:0] A_CONF = ADDR_W'(CONF_IDX);

  logic              stat_sel, conf_sel;
  logic [NCAUSE-1:0] cause;
  logic [NMODEM-1:0] delta;
  logic [3:0]        en, tx_code, rx_code;
  logic [31:0]       stat_word, conf_word;
  logic [TH_W-1:0]   th_out [2];
  logic [CODE_W-1:0] th_code [2];

  assign stat_sel = (bus_addr == A_STAT);
  assign conf_sel = (bus_addr == A_CONF);

  uirq_cause u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_in     ({tsa_evt, cto_evt, rda_evt, ls_evt}),
    .modem_lvl (modem_lvl),
    .clr_valid (bus_wr && stat_sel && bus_be[0]),
    .clr_mask  (bus_wdata[NCAUSE-1:0]),
    .cause     (cause),
    .delta     (delta)
  );

  uirq_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_wr && conf_sel),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .en      (en),
    .tx_code (tx_code),
    .rx_code (rx_code)
  );

  assign th_code[0] = tx_code[CODE_W-1:0];
  assign th_code[1] = rx_code[CODE_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_thresh
    uirq_thresh u_th (.code(th_code[g]), .bytes_out(th_out[g]));
  end

  assign tx_thresh = th_out[0];
  assign rx_thresh = th_out[1];

  assign irq = (cause[C_LS]  & en[EN_LS])
             | ((cause[C_RDA] | cause[C_CTO]) & en[EN_RX])
             | (cause[C_TSA] & en[EN_TX])
             | (cause[C_MS]  & en[EN_MS]);

  assign stat_word = {rx_fill[7:0], line_stat, modem_lvl, delta,
                      rx_fill[9:8], 1'b0, cause};
  assign conf_word = {8'h00, rx_code, tx_code, 12'h000, en};

  always_comb begin
    bus_rdata = '0;
    if (stat_sel)      bus_rdata = stat_word;
    else if (conf_sel) bus_rdata = conf_word;
  end

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[EN_RX] && cause[C_LS] == 1'b0 && cause[C_TSA] == 1'b0 && cause[C_MS] == 1'b0)
      |-> !irq);
endmodule

// File: tb/uart_irq_status_test.sv
`timescale 1ns/1ps
module uart_irq_status_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        ls_evt = 0, rda_evt = 0, cto_evt = 0, tsa_evt = 0;
  logic [3:0]  modem_lvl = 0;
  logic [7:0]  line_stat = 0;
  logic [9:0]  rx_fill = 0;
  logic        irq;
  logic [9:0]  tx_thresh, rx_thresh;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_status uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ls_evt(ls_evt), .rda_evt(rda_evt), .cto_evt(cto_evt), .tsa_evt(tsa_evt),
    .modem_lvl(modem_lvl), .line_stat(line_stat), .rx_fill(rx_fill),
    .irq(irq), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  // drive events (bits ls,rda,cto,tsa) plus optional status write in one cycle
  task automatic cycle(logic [3:0] ev, logic wr, logic [3:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    {tsa_evt, cto_evt, rda_evt, ls_evt} = ev;
    bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    {tsa_evt, cto_evt, rda_evt, ls_evt} = 0;
    bus_wr = 0;
  endtask

  task automatic clear_all();
    cycle(0, 1, 0, 4'h1, 32'h1f);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); check("R1 status", v & 32'h0f1f, 0);
    rd(1, v); check("R1 config", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_set_multi();
    logic [31:0] v;
    cycle(4'b0101, 0, 0, 0, 0);
    rd(0, v); check("R2 ls+cto", v[4:0], 5'b00101);
    cycle(4'b1010, 0, 0, 0, 0);
    rd(0, v); check("R2 all four", v[4:0], 5'b01111);
    cycle(0, 0, 0, 0, 0);
    rd(0, v); check("R2 held", v[4:0], 5'b01111);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    cycle(0, 1, 0, 4'hE, 32'h0000_001f);
    rd(0, v); check("R13 no lane0", v[4:0], 5'b01111);
    cycle(0, 1, 0, 4'h1, 32'h0000_0006);
    rd(0, v); check("R3 exact clear", v[4:0], 5'b01001);
    cycle(4'b0001, 1, 0, 4'h1, 32'h0000_0009);
    rd(0, v); check("R4 set wins", v[4:0], 5'b00001);
    clear_all();
    rd(0, v); check("R3 all clear", v[4:0], 0);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    cycle(4'b0010, 0, 0, 0, 0);
    check("R5 latched disabled irq", irq, 0);
    rd(0, v); check("R5 latched disabled bit", v[4:0], 5'b00010);
    cycle(0, 1, 1, 4'h1, 32'h2);
    check("R5 wrong enable", irq, 0);
    cycle(0, 1, 1, 4'h1, 32'h1);
    check("R6 rx enable rda", irq, 1);
    clear_all();
    check("R5 cleared irq", irq, 0);
    cycle(4'b0100, 0, 0, 0, 0);
    check("R6 rx enable cto", irq, 1);
    clear_all();
    for (int i = 0; i < 4; i++) begin
      logic [3:0] ev;
      logic [3:0] en;
      ev = 4'b1 << i;
      en = (i == 0) ? 4'b0100 : (i == 3) ? 4'b0010 : 4'b0001;
      cycle(0, 1, 1, 4'h1, {28'h0, en});
      cycle(ev, 0, 0, 0, 0);
      check("R5 matched enable", irq, 1);
      cycle(0, 1, 1, 4'h1, {28'h0, ~en});
      check("R5 other enables", irq, 0);
      clear_all();
    end
    cycle(0, 1, 1, 4'h1, 32'h0);
  endtask

  task automatic t_modem();
    logic [31:0] v;
    @(negedge clk); modem_lvl = 4'b0101;
    @(negedge clk);
    rd(0, v);
    check("R7 deltas", v[11:8], 4'b0101);
    check("R7 levels", v[15:12], 4'b0101);
    check("R7 ms cause", v[4], 1);
    cycle(0, 1, 1, 4'h1, 32'h8);
    check("R5 ms irq", irq, 1);
    cycle(0, 1, 0, 4'h1, 32'h1);
    rd(0, v); check("R8 ls clear keeps deltas", v[11:8], 4'b0101);
    cycle(0, 1, 0, 4'h1, 32'h10);
    rd(0, v);
    check("R8 deltas cleared", v[11:8], 0);
    check("R8 ms cleared", v[4], 0);
    check("R7 levels kept", v[15:12], 4'b0101);
    check("R8 irq low", irq, 0);
    cycle(0, 1, 1, 4'h1, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    line_stat = 8'hA5; rx_fill = 10'h2C3;
    rd(0, v);
    check("R9 line byte", v[23:16], 8'hA5);
    check("R10 fill low", v[31:24], 8'hC3);
    check("R10 fill high", v[7:6], 2'b10);
    check("R10 bit5", v[5], 0);
    cycle(0, 1, 0, 4'hF, 32'h0000_0000);
    rd(0, v);
    check("R10 write keeps fill", {v[7:6], v[31:24]}, 10'h2C3);
    check("R9 write keeps line", v[23:16], 8'hA5);
    rx_fill = 10'h1FF;
    rd(0, v); check("R10 fill 1ff", {v[7:6], v[31:24]}, 10'h1FF);
  endtask

  task automatic t_config();
    logic [31:0] v;
    cycle(0, 1, 1, 4'hF, 32'hFFFF_FFFF);
    rd(1, v); check("R11 readback all ones", v, 32'h00FF_000F);
    cycle(0, 1, 1, 4'h1, 32'h0065_0000);
    rd(1, v); check("R11 lane0 only", v, 32'h00FF_0000);
    cycle(0, 1, 1, 4'h4, 32'h0065_0000);
    rd(1, v); check("R11 lane2", v, 32'h0065_0000);
    check("R12 tx code5", tx_thresh, 128);
    check("R12 rx code6", rx_thresh, 256);
    for (int c = 0; c < 8; c++) begin
      cycle(0, 1, 1, 4'h4, {8'h0, 4'(7 - c), 4'(c), 16'h0});
      check("R12 tx sweep", tx_thresh, 32'(1) << (c + 2));
      check("R12 rx sweep", rx_thresh, 32'(1) << (9 - c));
    end
    cycle(0, 1, 1, 4'h4, 32'h00F8_0000);
    check("R12 code bit3 ignored tx", tx_thresh, 4);
    check("R12 code bit3 ignored rx", rx_thresh, 512);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_multi();
    t_clear();
    t_enables();
    t_modem();
    t_fields();
    t_config();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule